// File: doc/BRIEF.md
# Cosine-Symmetry Kernel Coefficient Generator

Each processing element of a systolic transform array needs one kernel coefficient. This generator supplies it from the element's row and column position and a kernel-type code. It never stores a full N×N kernel. It works out the angle index that the cosine basis would use at that position and reduces it to one of the N base angles of the kernel's first column. Segment k of a small ROM holds the first column of kernel type k, and the fold supplies the sign.

A configure strobe makes the generator capture a new coefficient. On the clock edge where the strobe is high, the element's coordinates and the selected kernel type are turned into a registered magnitude word and a registered sign. Both hold until the next strobe. The strobe also leaves the block one cycle later toward the right-hand and lower neighbours. A reconfiguration can therefore sweep across the array as a diagonal wavefront, and each element can use its new coefficient on the cycle after its strobe.

Top module: `kcoef_gen`

## Requirements
- R1: In reset the coefficient word, the sign bit and both forwarded strobes are driven to zero.
- R2: The angle index is f = ((2·col + 1)·row) mod 4N, where N = 2^LOG2N, in units of π/(2N).
- R3: The fold index is taken from the quadrant q = f div N. For q=0 it is f, for q=1 it is 2N−f, for q=2 it is f−2N and for q=3 it is 4N−f. It always lies in 0..N−1.
- R4: coef_neg is 1 (negative) exactly when q is 1 or 2, and 0 when q is 0 or 3.
- R5: The ROM address is {kern_sel, fold index}. For a kernel code s below 11, entry k holds ((s·N + k)·7 + 3) mod 1024, and coef_word presents that 10-bit word unchanged.
- R6: The word and the sign that result from row_idx, col_idx and kern_sel, sampled at a clock edge where cfg_in is 1, appear on the outputs directly after that edge.
- R7: While cfg_in is 0, coef_word and coef_neg keep their values whatever row_idx, col_idx and kern_sel do.
- R8: cfg_right and cfg_down each equal cfg_in delayed by one clock cycle.
- R9: A kernel code from 11 to 15 yields a coefficient word of 0. The sign still follows R4.
- R10: Strobes on consecutive cycles each capture their own inputs, so the outputs change on every such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in | input | 1 | Configure strobe from the left or upper neighbour |
| row_idx | input | LOG2N | Element row coordinate |
| col_idx | input | LOG2N | Element column coordinate |
| kern_sel | input | 4 | Kernel-type code (ROM segment) |
| cfg_right | output | 1 | Strobe forwarded to the right-hand neighbour |
| cfg_down | output | 1 | Strobe forwarded to the lower neighbour |
| coef_word | output | WW | Registered coefficient control word |
| coef_neg | output | 1 | Registered sign, 1 = negative |

## Verification
The bench runs a strobe for every row and column pair under all sixteen kernel codes. This covers every quadrant and fold branch, including row zero, and separates wrong segment addressing from a wrong fold or sign. Out-of-range codes are part of the sweep and show whether unused segments read as zero. Random strobes seeded from a fixed value are mixed with cycles in which cfg_in is low while the inputs change. These tell a capture-enable fault apart from a datapath fault. A directed pair of back-to-back strobes shows whether each edge captures its own inputs.

// File: rtl/kcoef_pkg.sv
package kcoef_pkg;
  typedef enum logic [1:0] {Q_FIRST, Q_SECOND, Q_THIRD, Q_FOURTH} quad_t;

  // Control word stored for segment seg, first-column entry idx.
  function automatic int ctl_word(int seg, int idx, int n, int nseg, int ww);
    if (seg >= nseg) return 0;
    return ((seg * n + idx) * 7 + 3) % (1 << ww);
  endfunction
endpackage

// File: rtl/kcoef_fold.sv
module kcoef_fold
  import kcoef_pkg::*;
#(
  parameter int LOG2N = 3
) (
  input  logic [LOG2N-1:0] row_idx,
  input  logic [LOG2N-1:0] col_idx,
  output quad_t            quad,
  output logic [LOG2N-1:0] fold_idx,
  output logic             neg
);
  localparam int FW = LOG2N + 2;

  logic [FW-1:0] odd_col, row_ext, angle;
  logic [LOG2N-1:0] low;

  assign odd_col = {1'b0, col_idx, 1'b1};
  assign row_ext = {2'b00, row_idx};
  // the product wraps to FW bits: angle modulo 4N
  assign angle = odd_col * row_ext;
  assign quad  = quad_t'(angle[FW-1 -: 2]);
  assign low   = angle[LOG2N-1:0];

  // 2N-f and 4N-f both reduce to N-low, f-2N reduces to low
  always_comb begin
    unique case (quad)
      Q_SECOND, Q_FOURTH: fold_idx = LOG2N'(0) - low;
      default:            fold_idx = low;
    endcase
  end

  assign neg = (quad == Q_SECOND) || (quad == Q_THIRD);
endmodule

// File: rtl/kcoef_rom.sv
module kcoef_rom
  import kcoef_pkg::*;
#(
  parameter int LOG2N = 3,
  parameter int NSEG  = 11,
  parameter int KW    = 4,
  parameter int WW    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [KW+LOG2N-1:0] addr,
  output logic [WW-1:0]       rdata
);
  localparam int N     = 1 << LOG2N;
  localparam int DEPTH = 1 << (KW + LOG2N);

  logic [WW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = WW'(ctl_word(i >> LOG2N, i % N, N, NSEG, WW));
  end

  // registered read with enable and output reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (en) rdata <= mem[addr];
  end
endmodule

// File: rtl/kcoef_relay.sv
module kcoef_relay #(
  parameter int NOUT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  output logic [NOUT-1:0] fwd
);
  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) fwd[g] <= 1'b0;
      else     fwd[g] <= strobe;
    end
  end
endmodule

// File: rtl/kcoef_gen.sv
module kcoef_gen
  import kcoef_pkg::*;
#(
  parameter int LOG2N = 3,
  parameter int NSEG  = 11,
  parameter int WW    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_in,
  input  logic [LOG2N-1:0]   row_idx,
  input  logic [LOG2N-1:0]   col_idx,
  input  logic [3:0]         kern_sel,
  output logic               cfg_right,
  output logic               cfg_down,
  output logic [WW-1:0]      coef_word,
  output logic               coef_neg
);
  localparam int KW = 4;

  quad_t            quad;
  logic [LOG2N-1:0] fold_idx;
  logic             neg;
  logic [1:0]       fwd;

  kcoef_fold #(.LOG2N(LOG2N)) u_fold (
    .row_idx (row_idx),
    .col_idx (col_idx),
    .quad    (quad),
    .fold_idx(fold_idx),
    .neg     (neg)
  );

  kcoef_rom #(.LOG2N(LOG2N), .NSEG(NSEG), .KW(KW), .WW(WW)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .en   (cfg_in),
    .addr ({kern_sel, fold_idx}),
    .rdata(coef_word)
  );

  always_ff @(posedge clk) begin
    if (rst)         coef_neg <= 1'b0;
    else if (cfg_in) coef_neg <= neg;
  end

  kcoef_relay #(.NOUT(2)) u_relay (
    .clk   (clk),
    .rst   (rst),
    .strobe(cfg_in),
    .fwd   (fwd)
  );
  assign cfg_right = fwd[0];
  assign cfg_down  = fwd[1];

  // R8
  relay_delay_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_right == $past(cfg_in)) && (cfg_down == $past(cfg_in)));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_in |=> $stable(coef_word) && $stable(coef_neg));

  // R4
  first_quad_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_in && quad == Q_FIRST) |=> !coef_neg);

  // R3
  odd_quad_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (quad == Q_SECOND || quad == Q_FOURTH) |-> fold_idx != '0);
endmodule

// File: tb/sim_kcoef_gen.sv
module sim_kcoef_gen;
  localparam int LOG2N = 3;
  localparam int N     = 1 << LOG2N;
  localparam int NSEG  = 11;
  localparam int WW    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_in = 1'b0;
  logic [LOG2N-1:0] row_idx = '0, col_idx = '0;
  logic [3:0] kern_sel = '0;
  logic cfg_right, cfg_down, coef_neg;
  logic [WW-1:0] coef_word;

  int checks = 0, errors = 0;
  int m_word = 0, m_neg = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kcoef_gen #(.LOG2N(LOG2N), .NSEG(NSEG), .WW(WW)) u0 (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .row_idx(row_idx), .col_idx(col_idx),
    .kern_sel(kern_sel), .cfg_right(cfg_right), .cfg_down(cfg_down),
    .coef_word(coef_word), .coef_neg(coef_neg));

  function automatic int e_off(int r, int c);
    int f = ((2 * c + 1) * r) % (4 * N);
    case (f / N)
      0: return f;
      1: return 2 * N - f;
      2: return f - 2 * N;
      default: return 4 * N - f;
    endcase
  endfunction

  function automatic int e_neg(int r, int c);
    int q = (((2 * c + 1) * r) % (4 * N)) / N;
    return (q == 1 || q == 2) ? 1 : 0;
  endfunction

  function automatic int e_word(int r, int c, int k);
    if (k >= NSEG) return 0;
    return ((k * N + e_off(r, c)) * 7 + 3) % 1024;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive after a falling edge, sample at the next falling edge
  task automatic step(input int r, input int c, input int k, input bit stb, input string ctx);
    row_idx  = LOG2N'(r);
    col_idx  = LOG2N'(c);
    kern_sel = 4'(k);
    cfg_in   = stb;
    @(negedge clk);
    if (stb) begin
      m_word = e_word(r, c, k);
      m_neg  = e_neg(r, c);
    end
    if (stb && k >= NSEG)
      chk(int'(coef_word) == m_word, {ctx, " R9 word"}, int'(coef_word), m_word);
    else if (stb)
      chk(int'(coef_word) == m_word, {ctx, " R2 R3 R5 R6 word"}, int'(coef_word), m_word);
    else
      chk(int'(coef_word) == m_word, {ctx, " R7 hold word"}, int'(coef_word), m_word);
    chk(int'(coef_neg) == m_neg, stb ? {ctx, " R4 sign"} : {ctx, " R7 hold sign"},
        int'(coef_neg), m_neg);
    chk(cfg_right == stb && cfg_down == stb, {ctx, " R8 relay"},
        int'({cfg_right, cfg_down}), stb ? 3 : 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(coef_word == '0 && coef_neg == 1'b0, "R1 reset coef", int'(coef_word), 0);
    chk(cfg_right == 1'b0 && cfg_down == 1'b0, "R1 reset relay", int'({cfg_right, cfg_down}), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < 16; k++)
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          step(r, c, k, 1'b1, "sweep");

    // R10 back-to-back strobes with distinct results
    step(3, 1, 2, 1'b1, "R10 first");
    step(5, 6, 7, 1'b1, "R10 second");
    step(0, 0, 0, 1'b0, "R10 idle");

    for (int i = 0; i < 400; i++)
      step(int'($urandom % N), int'($urandom % N), int'($urandom % 16),
           ($urandom % 4) != 0, "random");

    // R1 reset reasserted after a nonzero configuration
    step(7, 7, 10, 1'b1, "pre-reset");
    rst = 1'b1;
    @(negedge clk);
    chk(coef_word == '0 && coef_neg == 1'b0, "R1 reset again", int'(coef_word), 0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule